// File: doc/BRIEF.md
# Four-Channel Reloading Down-Counter Timer Bank

This block holds four independent 16-bit down-counters behind a byte-wide register bus. Software loads a reload value in two byte halves, starts or restarts a channel with a go command, and reads the count through a snapshot that a separate capture command freezes. A count that is read therefore never tears between its two bytes. All channels share one prescaler, which gives a count tick once every four clocks. A running channel steps down once per tick. When it reaches zero it reloads from its reload register and raises a one-clock expiry pulse.

Channel 2's expiry pulse is also the baud enable. Channel 3's expiry pulse also feeds a divide-by-16 stage, whose output is an enable for a 16x-oversampled serial clock. The asynchronous active-low reset is synchronised inside the block before it reaches any register.

Top module: `timer_bank`

## Requirements
- R1: After reset every snapshot reads 0 and no channel runs, so `expire`, `baud_en` and `ovs_baud_en` stay low until a go command.
- R2: Channel c owns byte addresses 0x40+16c to 0x4F+16c. Slot offset 0x0 is the low byte and 0x4 is the high byte. A write to either slot sets that byte of the channel's reload register. A read of either slot returns that byte of the channel's snapshot.
- R3: A write to slot 0x8 (go) loads the reload value into the counter and starts the channel. If a tick falls on the same clock edge, the go command takes precedence over it.
- R4: The shared tick is high on one clock in every four. A running counter decrements by one on each tick.
- R5: A tick that finds the counter at zero reloads it from the reload register. The channel's `expire` bit is then high for exactly the next clock, so expiries repeat every 4*(L+1) clocks, where L is the reload value.
- R6: `baud_en` equals `expire[2]` on every clock.
- R7: `ovs_baud_en` is high for one clock, one clock after every 16th channel 3 expiry, counted from reset.
- R8: The data byte written with a go or capture command is ignored. Only the write strobe acts.
- R9: Writes to addresses outside 0x40 to 0x7F have no effect. Reads return 0 at addresses outside that range and at the go and capture slots.
- R10: A write to slot 0xC (capture) copies the count value held just before that clock edge into the snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| expire | output | 4 | One-clock expiry pulse per channel |
| baud_en | output | 1 | Baud enable from channel 2 |
| ovs_baud_en | output | 1 | Channel 3 expiry divided by 16 |

## Verification
A command written in the cycle before edge g acts at edge g: a go sets the count after g, and a capture is visible on `bus_rdata` as soon as g has passed. The bench first measures the tick phase from a channel running with reload value 0. From then on it predicts each result exactly. An expiry is visible right after the (L+1)-th tick edge following the go, and `ovs_baud_en` one clock after the sixteenth channel 3 expiry. A captured value is L minus the number of tick edges after g and before the capture edge, taken modulo L+1. Outputs are sampled at the falling edge and reads 1 time unit after it. Every expected edge number comes from the bench's own clock counter.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;
  typedef enum logic [1:0] {
    SLOT_LO   = 2'd0,
    SLOT_HI   = 2'd1,
    SLOT_GO   = 2'd2,
    SLOT_SNAP = 2'd3
  } slot_e;
endpackage

// File: rtl/timer_bank_rst_sync.sv
module timer_bank_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/timer_bank_prescaler.sv
module timer_bank_prescaler #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;

  always_comb begin
    if (pre_q == PRE_LAST) pre_d = '0;
    else                   pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tick_o = (pre_q == PRE_LAST);

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o); // R4
endmodule

// File: rtl/timer_bank_channel.sv
module timer_bank_channel #(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic                  wr_lo_i,
  input  logic                  wr_hi_i,
  input  logic                  go_i,
  input  logic                  snap_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [2*DATA_W-1:0]   snap_o,
  output logic                  expire_o
);
  localparam int CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0] reload_q, reload_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] snap_q, snap_d;
  logic             run_q, run_d;
  logic             exp_q, exp_d;

  always_comb begin
    reload_d = reload_q;
    if (wr_lo_i) reload_d[DATA_W-1:0]     = wdata_i;
    if (wr_hi_i) reload_d[CNT_W-1:DATA_W] = wdata_i;
  end

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    exp_d = 1'b0;
    if (go_i) begin
      cnt_d = reload_q;
      run_d = 1'b1;
    end else if (run_q && tick_i) begin
      if (cnt_q == '0) begin
        cnt_d = reload_q;
        exp_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_comb begin
    snap_d = snap_i ? cnt_q : snap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      cnt_q    <= '0;
      snap_q   <= '0;
      run_q    <= 1'b0;
      exp_q    <= 1'b0;
    end else begin
      reload_q <= reload_d;
      cnt_q    <= cnt_d;
      snap_q   <= snap_d;
      run_q    <= run_d;
      exp_q    <= exp_d;
    end
  end

  assign snap_o   = snap_q;
  assign expire_o = exp_q;

  AST_GO_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |=> (cnt_q == $past(reload_q)) && run_q); // R3
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick_i && !go_i && (cnt_q != '0)) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1))); // R4
  AST_EXPIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !expire_o); // R5
  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !expire_o); // R1
  AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    snap_i |=> (snap_o == $past(cnt_q))); // R10
endmodule

// File: rtl/timer_bank_ovs_div.sv
module timer_bank_ovs_div #(
  parameter int OVS_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_i,
  output logic pulse_o
);
  localparam int DIV_W = (OVS_DIV > 1) ? $clog2(OVS_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(OVS_DIV - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic             out_q, out_d;

  always_comb begin
    div_d = div_q;
    out_d = 1'b0;
    if (pulse_i) begin
      if (div_q == DIV_LAST) begin
        div_d = '0;
        out_d = 1'b1;
      end else begin
        div_d = div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      out_q <= 1'b0;
    end else begin
      div_q <= div_d;
      out_q <= out_d;
    end
  end

  assign pulse_o = out_q;

  AST_OVS_FOLLOWS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> $past(pulse_i)); // R7
  AST_OVS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o); // R7
endmodule

// File: rtl/timer_bank.sv
module timer_bank #(
  parameter int NUM_CH    = 4,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 8,
  parameter int CH_BASE   = 'h40,
  parameter int CH_STRIDE = 16,
  parameter int TICK_DIV  = 4,
  parameter int BAUD_CH   = 2,
  parameter int OVS_CH    = 3,
  parameter int OVS_DIV   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] expire,
  output logic              baud_en,
  output logic              ovs_baud_en
);
  import timer_bank_pkg::*;

  localparam int CNT_W    = 2 * DATA_W;
  localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int CH_LSB   = $clog2(CH_STRIDE);
  localparam int SLOT_LSB = 2;
  localparam int SPAN     = NUM_CH * CH_STRIDE;

  logic                rst_sync_n;
  logic                tick;
  logic [ADDR_W-1:0]   rel_addr;
  logic                in_range;
  logic [CH_IDX_W-1:0] ch_idx;
  slot_e               slot;
  logic [CNT_W-1:0]    snap_w [NUM_CH];

  timer_bank_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  timer_bank_prescaler #(.TICK_DIV(TICK_DIV)) u_prescaler (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick_o (tick)
  );

  always_comb begin
    rel_addr = bus_addr - ADDR_W'(CH_BASE);
    in_range = (bus_addr >= ADDR_W'(CH_BASE)) && ({1'b0, rel_addr} < (ADDR_W+1)'(SPAN));
    ch_idx   = rel_addr[CH_LSB +: CH_IDX_W];
    slot     = slot_e'(rel_addr[SLOT_LSB +: 2]);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel;
    assign sel = bus_wr && in_range && (ch_idx == CH_IDX_W'(c));

    timer_bank_channel #(.DATA_W(DATA_W)) u_channel (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .tick_i   (tick),
      .wr_lo_i  (sel && (slot == SLOT_LO)),
      .wr_hi_i  (sel && (slot == SLOT_HI)),
      .go_i     (sel && (slot == SLOT_GO)),
      .snap_i   (sel && (slot == SLOT_SNAP)),
      .wdata_i  (bus_wdata),
      .snap_o   (snap_w[c]),
      .expire_o (expire[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (in_range) begin
      case (slot)
        SLOT_LO: bus_rdata = snap_w[ch_idx][DATA_W-1:0];
        SLOT_HI: bus_rdata = snap_w[ch_idx][CNT_W-1:DATA_W];
        default: bus_rdata = '0;
      endcase
    end
  end

  assign baud_en = expire[BAUD_CH];

  timer_bank_ovs_div #(.OVS_DIV(OVS_DIV)) u_ovs_div (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .pulse_i (expire[OVS_CH]),
    .pulse_o (ovs_baud_en)
  );

  AST_RD_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_range |-> (bus_rdata == '0)); // R9
  AST_EXPIRE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (expire != '0) |-> $past(tick)); // R5
endmodule

// File: tb/timer_bank_tb_top.sv
module timer_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [3:0] expire;
  logic       baud_en;
  logic       ovs_baud_en;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int phase = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  timer_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .expire(expire),
    .baud_en(baud_en), .ovs_baud_en(ovs_baud_en)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ticks_between(input int a, input int b);
    int n = 0;
    for (int e = a + 1; e <= b; e++) if ((e % TDIV) == phase) n++;
    return n;
  endfunction

  function automatic int count_at(input int g, input int s, input int l);
    int k = ticks_between(g, s - 1);
    return l - (k % (l + 1));
  endfunction

  function automatic int first_expiry(input int g, input int l);
    int n = 0;
    int e = g;
    while (n < l + 1) begin
      e++;
      if ((e % TDIV) == phase) n++;
    end
    return e;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d, output int edge_n);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    edge_n = cyc + 1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int d);
    bus_addr = a;
    #1;
    d = int'(bus_rdata);
  endtask

  task automatic rd16(input int ch, output int v);
    int lo, hi;
    rd(8'(8'h40 + 16*ch), lo);
    rd(8'(8'h44 + 16*ch), hi);
    v = hi * 256 + lo;
  endtask

  task automatic wait_exp(input int ch, input int maxc, output int edge_n);
    edge_n = -1;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (expire[ch]) begin edge_n = cyc; return; end
    end
  endtask

  task automatic load(input int ch, input int l, output int g);
    int e;
    wr(8'(8'h40 + 16*ch), 8'(l), e);
    wr(8'(8'h44 + 16*ch), 8'(l >> 8), e);
    wr(8'(8'h48 + 16*ch), 8'h5A, g);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  initial begin
    int g, s, e, e2, v, cnt_bad, last, l;
    bit quiet;
    void'($urandom(32'd1234));
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    for (int c = 0; c < 4; c++) begin
      rd16(c, v);
      check("R1 snapshot zero", v, 0);
    end
    quiet = 1;
    repeat (100) begin
      @(negedge clk);
      if (expire != 0 || baud_en || ovs_baud_en) quiet = 0;
    end
    check("R1 stopped", quiet, 1);

    // Calibrate tick phase with channel 0 at reload 0
    load(0, 0, g);
    wait_exp(0, 40, e);
    phase = e % TDIV;
    check("R5 first expiry L=0", e, first_expiry(g, 0));
    @(negedge clk);
    check("R5 one-cycle pulse", int'(expire[0]), 0);
    wait_exp(0, 40, e2);
    check("R4 tick period", e2 - e, TDIV);

    // R2 R3 R8: halves, go with junk data, capture right after go
    wr(8'h50, 8'h34, e);
    wr(8'h54, 8'h12, e);
    wr(8'h58, 8'hA5, g);
    wr(8'h5C, 8'hFF, s);
    rd16(1, v);
    check("R3 R8 go loads reload", v, count_at(g, s, 16'h1234));
    rd(8'h50, v); check("R2 low half", v, 8'h34);
    rd(8'h54, v); check("R2 high half", v, 8'h12);
    repeat (37) @(negedge clk);
    wr(8'h5C, 8'h00, s);
    rd16(1, v);
    check("R10 R4 capture after run", v, count_at(g, s, 16'h1234));

    // R9: out-of-range writes and reads
    wr(8'h9C, 8'h00, e);
    wr(8'h0C, 8'h00, e);
    wr(8'h98, 8'h00, e);
    rd16(1, e2);
    check("R9 snapshot unchanged", e2, v);
    rd(8'h90, v); check("R9 read above range", v, 0);
    rd(8'h20, v); check("R9 read below range", v, 0);
    rd(8'h58, v); check("R9 read go slot", v, 0);
    rd(8'h5C, v); check("R9 read capture slot", v, 0);

    // R5: reload period with L=5 on channel 1
    load(1, 5, g);
    wait_exp(1, 200, e);
    check("R5 first expiry L=5", e, first_expiry(g, 5));
    @(negedge clk);
    check("R5 pulse width", int'(expire[1]), 0);
    wait_exp(1, 200, e2);
    check("R5 period L=5", e2 - e, TDIV * 6);

    // R6: baud enable from channel 2
    load(2, 3, g);
    cnt_bad = 0; last = -1; e2 = 0;
    repeat (200) begin
      @(negedge clk);
      if (baud_en != expire[2]) cnt_bad++;
      if (baud_en) begin
        if (last >= 0 && cyc - last != TDIV * 4) e2++;
        last = cyc;
      end
    end
    check("R6 baud equals expire2", cnt_bad, 0);
    check("R6 baud period", e2, 0);
    check("R6 baud seen", int'(last >= 0), 1);

    // R7: oversampled enable from channel 3
    load(3, 0, g);
    e = first_expiry(g, 0) + 15 * TDIV + 1;
    last = -1;
    for (int i = 0; i < 200 && last < 0; i++) begin
      @(negedge clk);
      if (ovs_baud_en) last = cyc;
    end
    check("R7 first ovs enable", last, e);
    last = -1;
    for (int i = 0; i < 200 && last < 0; i++) begin
      @(negedge clk);
      if (ovs_baud_en) last = cyc;
    end
    check("R7 ovs period", last - e, TDIV * 16);

    // R4 R10: random reloads and capture points
    for (int i = 0; i < 24; i++) begin
      int ch = int'($urandom_range(0, 3));
      l = (i % 2) ? int'($urandom_range(0, 9)) : int'($urandom_range(0, 65535));
      load(ch, l, g);
      repeat (int'($urandom_range(0, 70))) @(negedge clk);
      wr(8'(8'h4C + 16*ch), 8'($urandom), s);
      rd16(ch, v);
      check("R4 R10 random capture", v, count_at(g, s, l));
    end

    done = 1;
    finish_run();
  end
endmodule